// File: doc/BRIEF.md
# Sectored Program Cache Controller

This block is a read-only program cache that sits between a processor's 24-bit instruction fetch port and a slow external program memory. It holds 1024 instruction words organised as eight sectors of 128 words. Each sector is bound to one upper-address tag. Each word inside a sector has its own valid bit, so a sector fills one word at a time as the program touches it. There is no line refill.

A fetch whose word is resident returns in one cycle, the same as internal memory. A fetch that misses issues a single-word external read. The read waits the number of wait states given on a 4-bit input, then the fetched word is handed to the processor and written into the cache in the same cycle. A miss therefore costs nothing beyond the external access itself. The first pass through a loop body misses and fills the cache, and every later pass hits.

When no sector carries the fetched tag, the least-recently-used sector is taken over. Its tag is replaced and all its valid bits are cleared. Clearing the enable input sends every fetch to external memory and leaves the cache contents untouched.

Top module: `prog_sector_cache`

## Requirements
- R1: The fetch address is split into a word index (bits 6:0) and a tag (bits 23:7). Addresses that differ in any tag bit, including bit 7, never share a sector entry.
- R2: An enabled fetch of a resident word raises fetch_ready exactly one cycle after the request is sampled, with the correct word on fetch_data. ext_req stays low.
- R3: A fetch that is not a hit raises ext_req with ext_addr equal to the fetch address. ext_rdata is sampled when ext_req has been high for wait_states+1 rising edges. fetch_ready follows exactly wait_states+2 cycles after the request is sampled, carrying the external word.
- R4: After an enabled miss, a repeated fetch of the same address hits.
- R5: Each word has its own valid bit. A word that has not been fetched misses even when its sector's tag matches. Filling it does not disturb the other words of that sector.
- R6: When no sector holds the tag, the least-recently-used sector is reallocated and all its previously held words miss afterwards. Other sectors keep their words.
- R7: Recency order among the sectors is refreshed on every hit and every allocation. After reset, sectors are reallocated in the order 0, 1, 2, and so on.
- R8: With cache_en low, every fetch goes external with miss timing. Cache contents, tags and recency order stay unchanged.
- R9: Synchronous reset clears all valid bits and the recency order. After reset, fetch_ready and ext_req are low and every fetch misses.
- R10: ext_addr holds steady for as long as ext_req is high.
- R11: Every wait-state count from 0 to 15 is honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | 1 = cache in use, 0 = bypass all fetches |
| wait_states | input | 4 | External memory wait states, sampled with each request |
| fetch_req | input | 1 | Fetch request, sampled while the block is idle |
| fetch_addr | input | 24 | Fetch word address |
| fetch_ready | output | 1 | One-cycle pulse: fetch_data is valid |
| fetch_data | output | 24 | Fetched instruction word |
| ext_req | output | 1 | External read in progress |
| ext_addr | output | 24 | External read address |
| ext_rdata | input | 24 | External read data |

## Verification
A stale valid bit or a wrong tag shows up on the very next fetch of that address. The failure appears either as a one-cycle return carrying the wrong word, or as a needless external access that stretches the latency to wait_states+2 cycles.

A corrupted recency order stays hidden until the ninth distinct tag forces a reallocation. At that point the wrong sector loses its words, and later fetches to the sector that should have survived return with miss latency.

The bench therefore checks both latency and data on every fetch against an arithmetic model. It sweeps every wait-state count and drives replacement sequences long enough to expose recency errors.

// File: rtl/scache_pkg.sv
package scache_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_EXT  = 1'b1
  } cache_st_e;
endpackage

// File: rtl/scache_data_ram.sv
module scache_data_ram #(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/scache_sector_tags.sv
module scache_sector_tags #(
  parameter int SECTORS = 8,
  parameter int WORDS   = 128,
  parameter int TAG_W   = 17,
  localparam int SEC_W  = $clog2(SECTORS),
  localparam int IDX_W  = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             match_any,
  output logic [SEC_W-1:0] match_sec,
  output logic             word_hit,
  input  logic             upd_en,
  input  logic             upd_alloc,
  input  logic [SEC_W-1:0] upd_sec,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic [IDX_W-1:0] upd_idx
);
  logic [TAG_W-1:0]   tag_q   [SECTORS];
  logic [SECTORS-1:0] alloc_q;
  logic [WORDS-1:0]   valid_q [SECTORS];
  logic [SECTORS-1:0] match_vec;
  logic               any_valid;

  // tag storage: no reset needed, alloc_q qualifies it
  always_ff @(posedge clk) begin
    if (!rst && upd_en && upd_alloc) tag_q[upd_sec] <= upd_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alloc_q <= '0;
      for (int s = 0; s < SECTORS; s++) valid_q[s] <= '0;
    end else if (upd_en) begin
      if (upd_alloc) begin
        alloc_q[upd_sec] <= 1'b1;
        valid_q[upd_sec] <= WORDS'(1) << upd_idx;
      end else begin
        valid_q[upd_sec][upd_idx] <= 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < SECTORS; g++) begin : g_cmp
      assign match_vec[g] = alloc_q[g] && (tag_q[g] == lk_tag);
    end
  endgenerate

  always_comb begin
    match_sec = '0;
    for (int s = SECTORS - 1; s >= 0; s--) begin
      if (match_vec[s]) match_sec = SEC_W'(s);
    end
  end

  assign match_any = |match_vec;
  assign word_hit  = match_any && valid_q[match_sec][lk_idx];

  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < SECTORS; s++) any_valid = any_valid | (|valid_q[s]);
  end

  // a tag is never held by two sectors at once
  assert_single_owner_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> !any_valid);

  // a fresh allocation leaves exactly one valid word in its sector
  assert_alloc_one_word_R6: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_alloc) |=> ($countones(valid_q[$past(upd_sec)]) == 1));
endmodule

// File: rtl/scache_lru.sv
module scache_lru #(
  parameter int SECTORS = 8,
  localparam int SEC_W  = $clog2(SECTORS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [SEC_W-1:0] touch_sec,
  output logic [SEC_W-1:0] victim_sec
);
  // rank 0 = most recently used, SECTORS-1 = next victim
  logic [SEC_W-1:0]   rank_q [SECTORS];
  logic [SECTORS-1:0] used;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SECTORS; s++) rank_q[s] <= SEC_W'(SECTORS - 1 - s);
    end else if (touch_en) begin
      for (int s = 0; s < SECTORS; s++) begin
        if (SEC_W'(s) == touch_sec)             rank_q[s] <= '0;
        else if (rank_q[s] < rank_q[touch_sec]) rank_q[s] <= rank_q[s] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_sec = '0;
    for (int s = 0; s < SECTORS; s++) begin
      if (rank_q[s] == SEC_W'(SECTORS - 1)) victim_sec = SEC_W'(s);
    end
  end

  always_comb begin
    used = '0;
    for (int s = 0; s < SECTORS; s++) used[rank_q[s]] = 1'b1;
  end

  assert_rank_permutation_R7: assert property (@(posedge clk) disable iff (rst)
    &used);

  assert_touch_mru_R7: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> (rank_q[$past(touch_sec)] == '0));
endmodule

// File: rtl/prog_sector_cache.sv
module prog_sector_cache #(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 24,
  parameter int SECTORS = 8,
  parameter int WORDS   = 128,
  parameter int WS_W    = 4,
  localparam int SEC_W  = $clog2(SECTORS),
  localparam int IDX_W  = $clog2(WORDS),
  localparam int TAG_W  = ADDR_W - IDX_W,
  localparam int RAM_AW = SEC_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cache_en,
  input  logic [WS_W-1:0]   wait_states,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic [DATA_W-1:0] fetch_data,
  output logic              ext_req,
  output logic [ADDR_W-1:0] ext_addr,
  input  logic [DATA_W-1:0] ext_rdata
);
  import scache_pkg::*;

  cache_st_e         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              en_q;
  logic [WS_W-1:0]   ws_q;
  logic [WS_W-1:0]   cnt_q;
  logic [SEC_W-1:0]  sec_q;
  logic              alloc_q;
  logic [DATA_W-1:0] miss_data_q;
  logic              out_sel_q;
  logic              ready_q;
  logic              ext_req_q;

  logic [TAG_W-1:0]  lk_tag;
  logic [IDX_W-1:0]  lk_idx;
  logic              match_any;
  logic [SEC_W-1:0]  match_sec;
  logic              word_hit;
  logic [SEC_W-1:0]  victim_sec;
  logic              take;
  logic              hit;
  logic              done;
  logic              fill;
  logic              touch_en;
  logic [SEC_W-1:0]  touch_sec;
  logic [DATA_W-1:0] ram_q;

  assign lk_tag = fetch_addr[ADDR_W-1:IDX_W];
  assign lk_idx = fetch_addr[IDX_W-1:0];
  assign take   = (st_q == ST_IDLE) && fetch_req;
  assign hit    = cache_en && word_hit;
  assign done   = (st_q == ST_EXT) && (cnt_q == ws_q);
  assign fill   = done && en_q;

  assign touch_en  = (take && hit) || fill;
  assign touch_sec = fill ? sec_q : match_sec;

  scache_sector_tags #(
    .SECTORS(SECTORS), .WORDS(WORDS), .TAG_W(TAG_W)
  ) u_tags (
    .clk      (clk),
    .rst      (rst),
    .lk_tag   (lk_tag),
    .lk_idx   (lk_idx),
    .match_any(match_any),
    .match_sec(match_sec),
    .word_hit (word_hit),
    .upd_en   (fill),
    .upd_alloc(alloc_q),
    .upd_sec  (sec_q),
    .upd_tag  (addr_q[ADDR_W-1:IDX_W]),
    .upd_idx  (addr_q[IDX_W-1:0])
  );

  scache_lru #(.SECTORS(SECTORS)) u_lru (
    .clk       (clk),
    .rst       (rst),
    .touch_en  (touch_en),
    .touch_sec (touch_sec),
    .victim_sec(victim_sec)
  );

  scache_data_ram #(.DATA_W(DATA_W), .DEPTH(SECTORS * WORDS)) u_ram (
    .clk  (clk),
    .we   (fill),
    .waddr(RAM_AW'({sec_q, addr_q[IDX_W-1:0]})),
    .wdata(ext_rdata),
    .raddr(RAM_AW'({match_sec, lk_idx})),
    .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      ready_q   <= 1'b0;
      ext_req_q <= 1'b0;
      out_sel_q <= 1'b0;
      cnt_q     <= '0;
      en_q      <= 1'b0;
      ws_q      <= '0;
      alloc_q   <= 1'b0;
      sec_q     <= '0;
      addr_q    <= '0;
    end else begin
      ready_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (take) begin
            if (hit) begin
              ready_q   <= 1'b1;
              out_sel_q <= 1'b0;
            end else begin
              st_q      <= ST_EXT;
              addr_q    <= fetch_addr;
              en_q      <= cache_en;
              ws_q      <= wait_states;
              cnt_q     <= '0;
              sec_q     <= match_any ? match_sec : victim_sec;
              alloc_q   <= !match_any;
              ext_req_q <= 1'b1;
            end
          end
        end
        ST_EXT: begin
          if (done) begin
            st_q      <= ST_IDLE;
            ready_q   <= 1'b1;
            out_sel_q <= 1'b1;
            ext_req_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (done) miss_data_q <= ext_rdata;
  end

  assign fetch_ready = ready_q;
  assign fetch_data  = out_sel_q ? miss_data_q : ram_q;
  assign ext_req     = ext_req_q;
  assign ext_addr    = addr_q;

  assert_hit_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (take && hit) |=> (fetch_ready && !ext_req));

  assert_ready_no_ext_R2: assert property (@(posedge clk) disable iff (rst)
    fetch_ready |-> !ext_req);

  assert_bypass_goes_ext_R8: assert property (@(posedge clk) disable iff (rst)
    (take && !cache_en) |=> ext_req);

  assert_ext_addr_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (ext_req && $past(ext_req)) |-> $stable(ext_addr));

  assert_wait_bound_R11: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_EXT) |-> (cnt_q <= ws_q));
endmodule

// File: tb/prog_sector_cache_bench.sv
module prog_sector_cache_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cache_en;
  logic [3:0]  wait_states;
  logic        fetch_req;
  logic [23:0] fetch_addr;
  logic        fetch_ready;
  logic [23:0] fetch_data;
  logic        ext_req;
  logic [23:0] ext_addr;
  logic [23:0] ext_rdata;
  logic [4:0]  ext_cnt;

  int n_tests = 0;
  int n_fail  = 0;

  // model state
  int           m_rank  [8];
  bit           m_alloc [8];
  logic [16:0]  m_tag   [8];
  bit [127:0]   m_valid [8];

  always #(CLK_PERIOD / 2) clk = ~clk;

  prog_sector_cache u_prog_sector_cache (
    .clk(clk), .rst(rst), .cache_en(cache_en), .wait_states(wait_states),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
    .fetch_data(fetch_data), .ext_req(ext_req), .ext_addr(ext_addr),
    .ext_rdata(ext_rdata)
  );

  function automatic logic [23:0] mem_word(input logic [23:0] a);
    return {a[11:0], a[23:12]} ^ 24'h5A3C96;
  endfunction

  // external memory: data valid only on the wait_states-th counted edge
  always @(posedge clk) ext_cnt <= ext_req ? ext_cnt + 5'd1 : 5'd0;
  assign ext_rdata = (ext_req && ext_cnt == {1'b0, wait_states}) ?
                     mem_word(ext_addr) : ~mem_word(ext_addr);

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 8; s++) begin
      m_rank[s] = 7 - s; m_alloc[s] = 0; m_valid[s] = '0; m_tag[s] = '0;
    end
  endtask

  task automatic model_touch(input int s);
    int old = m_rank[s];
    for (int t = 0; t < 8; t++) if (m_rank[t] < old) m_rank[t]++;
    m_rank[s] = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1; fetch_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    check(fetch_ready == 1'b0, "R9", "ready after reset", fetch_ready, 0);
    check(ext_req == 1'b0, "R9", "ext_req after reset", ext_req, 0);
  endtask

  task automatic do_fetch(input logic [23:0] a, input string rq,
                          output bit was_hit);
    int ms = -1;
    int lat = 0;
    bit exp_hit;
    bit saw_ext = 0;
    logic [16:0] tg = a[23:7];
    int ix = int'(a[6:0]);
    for (int s = 0; s < 8; s++) if (m_alloc[s] && m_tag[s] == tg) ms = s;
    exp_hit = cache_en && (ms >= 0) && m_valid[ms][ix];
    fetch_req = 1'b1; fetch_addr = a;
    do begin
      @(negedge clk);
      lat++;
      if (ext_req) saw_ext = 1;
    end while (!fetch_ready && lat < 40);
    fetch_req = 1'b0;
    check(lat == (exp_hit ? 1 : int'(wait_states) + 2), rq, "latency",
          lat, exp_hit ? 1 : int'(wait_states) + 2);
    check(fetch_data == mem_word(a), rq, "data", fetch_data, mem_word(a));
    if (exp_hit) check(!saw_ext, rq, "no ext on hit", saw_ext, 0);
    was_hit = (lat == 1);
    if (cache_en) begin
      if (exp_hit) model_touch(ms);
      else if (ms >= 0) begin
        m_valid[ms][ix] = 1'b1; model_touch(ms);
      end else begin
        int v = 0;
        for (int s = 0; s < 8; s++) if (m_rank[s] == 7) v = s;
        m_tag[v] = tg; m_alloc[v] = 1'b1; m_valid[v] = '0;
        m_valid[v][ix] = 1'b1; model_touch(v);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit h;
    logic [31:0] lcg;
    cache_en = 1'b1; wait_states = 4'd3; fetch_addr = '0; fetch_req = 1'b0;
    do_reset();

    // R11 / R3 / R4: loop body run three times for every wait-state count
    for (int w = 0; w < 16; w++) begin
      wait_states = 4'(w);
      for (int p = 0; p < 3; p++)
        for (int k = 0; k < 6; k++) begin
          do_fetch(24'h001200 + 24'(w * 8 + k), p == 0 ? "R3_R11" : "R4", h);
          check(h == (p != 0), p == 0 ? "R3" : "R4", "hit flag", h, p != 0);
        end
    end

    // R1: bit 7 belongs to the tag
    do_reset();
    wait_states = 4'd2;
    do_fetch(24'h000005, "R1", h);
    do_fetch(24'h000085, "R1", h);
    check(!h, "R1", "bit7 alias hit", h, 0);
    do_fetch(24'h000005, "R1", h);
    check(h, "R1", "first word kept", h, 1);

    // R5: per-word valid inside a matched sector
    do_fetch(24'h000006, "R5", h);
    check(!h, "R5", "unfilled word", h, 0);
    do_fetch(24'h000005, "R5", h);
    check(h, "R5", "neighbour kept", h, 1);

    // R6 / R7: fill eight tags, refresh tag 1, ninth tag evicts tag 2
    do_reset();
    wait_states = 4'd1;
    for (int t = 1; t <= 8; t++) do_fetch(24'(t) << 7, "R7", h);
    do_fetch(24'h000080, "R7", h);
    check(h, "R7", "refreshed tag hit", h, 1);
    do_fetch(24'h000480, "R6", h);
    do_fetch(24'h000100, "R6", h);
    check(!h, "R6", "evicted sector", h, 0);
    do_fetch(24'h000080, "R6", h);
    check(h, "R6", "survivor sector", h, 1);

    // R8: bypass leaves contents alone
    cache_en = 1'b0;
    do_fetch(24'h000080, "R8", h);
    check(!h, "R8", "bypassed resident", h, 0);
    do_fetch(24'h00F000, "R8", h);
    cache_en = 1'b1;
    do_fetch(24'h000080, "R8", h);
    check(h, "R8", "still resident", h, 1);
    do_fetch(24'h00F000, "R8", h);
    check(!h, "R8", "bypass not filled", h, 0);

    // mixed sweep over 12 tags, model-checked (R2 R3 R6 R7)
    lcg = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      wait_states = 4'(i % 5);
      cache_en = (lcg[31:28] != 4'hF);
      do_fetch({7'd0, 4'(lcg[15:12] % 12), 6'd0, lcg[20:14] & 7'h0F},
               "R2_R6_R7", h);
    end
    cache_en = 1'b1;

    // R9: reset drops all contents
    do_fetch(24'h000080, "R9", h);
    do_reset();
    do_fetch(24'h000080, "R9", h);
    check(!h, "R9", "hit after reset", h, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule